// File: doc/BRIEF.md
# Timed Asynchronous SRAM Controller

This block lets synchronous logic use an external asynchronous static RAM that is 16 bits wide and has one enable per byte lane. On the request side there is a valid/ready handshake. Each request carries a direction flag, an 18-bit word address, write data and a byte-lane mask. Read results come back with a single-cycle valid strobe. On the memory side the block drives the address and the active-low chip select, output enable, write strobe and byte-lane enables. For the data pins it provides a separate output path, an input path and a driver enable, and the bidirectional pad sits outside the block.

Every bus phase is a whole number of clock cycles. Each count is computed at elaboration from a nanosecond timing and the clock period, and rounded up with a floor of one cycle. The nanosecond timings default to a fast (55 ns) grade or a slow (70 ns) grade, chosen by one parameter. A read keeps address, chip select and output enable asserted. The data is sampled only once both the address access time and the output-enable access time have elapsed, and always before the address can change. A write is terminated by the write strobe. Output enable stays high for the whole write, and the data driver is on only while the write strobe is low, plus one cycle after it rises for hold time. Between transactions the chip select is high, which leaves the memory in standby.

Top module: `sram_timed_ctrl`

## Requirements
- R1: While reset is held and on the first clock after it, chip select, output enable, write strobe and both byte enables are high, the data driver is off, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Each phase length is max(1, ceil(t_ns / CLK_PERIOD_NS)). With the defaults (5 ns clock, fast grade) the values are:
  - read: 11 cycles, with data sampled at the end of cycle 11;
  - write: 11 cycles, with 1 cycle of address setup and an 8-cycle write pulse.
- R3: In the cycle after a read with a non-zero mask is accepted, chip select and output enable go low and the address bus carries the request address. Mask bit 0 drives the low-byte enable and mask bit 1 drives the high-byte enable, each active low, so a mask bit of 1 gives an enable of 0.
- R4: For a read, `rsp_valid` pulses for one cycle in the cycle after the data is sampled. With the defaults this is the 11th cycle after acceptance. `rsp_rdata` holds the memory word, with every byte lane whose mask bit is 0 forced to zero.
- R5: During a write, output enable stays high. The write strobe is low from write cycle 1 through write cycle 8, counting the first cycle after acceptance as cycle 0.
- R6: The data driver is on from the cycle after the write strobe falls until the cycle after it rises (write cycles 2 to 9 with defaults). While it is on, `sram_dq_out` carries the write data and output enable is high.
- R7: `req_ready` is low for the full read or write length after acceptance, so no request is accepted while the bus is busy.
- R8: A request whose mask is zero runs no bus cycle, and `req_ready` stays high. For a zero-mask read, `rsp_valid` pulses in the next cycle with `rsp_rdata` equal to 0.
- R9: Whenever the controller is idle (`req_ready` high), chip select and both byte enables are high.
- R10: While chip select stays low, the address bus does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lanes, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle read-result strobe |
| rsp_rdata | output | 16 | Read result, disabled lanes zero |
| sram_addr | output | 18 | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_be_n | output | 2 | Byte enables, bit 0 low byte, bit 1 high byte, active low |
| sram_dq_out | output | 16 | Data to the pad driver |
| sram_dq_oe | output | 1 | Pad driver enable |
| sram_dq_in | input | 16 | Data from the pad |

## Verification
A bus transaction drives its memory pins in the first cycle after the accepting edge. The write strobe falls one cycle after that, and the driver enable one cycle after the strobe falls. Read data is due exactly one cycle after the sampling edge, and ready returns one cycle after the last bus cycle. The reference model counts its own cycle offset from each acceptance and predicts every pin for every cycle, and the bench compares them half a cycle after each edge. The bench's memory model presents garbage on the data inputs until the sampling edge, and garbage on disabled lanes at all times, so an early sample or a missing lane mask appears as wrong read data.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } ctl_state_e;

  // Whole cycles covering a nanosecond interval, never below one.
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_counter.sv
`timescale 1ns/1ps
module sram_cycle_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);

  always_comb begin
    cnt_d = cnt_q;
    if (start)    cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sram_write_shaper.sv
`timescale 1ns/1ps
module sram_write_shaper #(
  parameter int CNT_W     = 4,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_next,
  input  logic [CNT_W-1:0] cnt_next,
  output logic             we_n,
  output logic             dq_oe
);

  localparam logic [CNT_W-1:0] WE_ON  = CNT_W'(SETUP_CYC);
  localparam logic [CNT_W-1:0] WE_OFF = CNT_W'(SETUP_CYC + PULSE_CYC);
  localparam logic [CNT_W-1:0] DRV_ON = CNT_W'(SETUP_CYC + 1);

  logic we_win, drv_win;

  // Strobe window, then a driver window shifted one cycle later.
  assign we_win  = wr_next && (cnt_next >= WE_ON)  && (cnt_next <  WE_OFF);
  assign drv_win = wr_next && (cnt_next >= DRV_ON) && (cnt_next <= WE_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      we_n  <= !we_win;
      dq_oe <= drv_win;
    end
  end

  // R6: driver turns on only after the strobe has already been low a cycle
  assert_drive_after_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> (!we_n && $past(!we_n)));

  // R6: data is still driven on the edge where the strobe rises
  assert_hold_at_strobe_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> dq_oe);

  // R6: driver is released one cycle after the strobe rises
  assert_release_after_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (we_n && $past(we_n)) |-> !dq_oe);

endmodule

// File: rtl/sram_read_capture.sv
`timescale 1ns/1ps
module sram_read_capture #(
  parameter int DATA_W  = 16,
  parameter int LANES   = 2,
  parameter int CNT_W   = 4,
  parameter int CAP_CYC = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_read,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              zero_read,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int               LANE_W = DATA_W / LANES;
  localparam logic [CNT_W-1:0] CAP_AT = CNT_W'(CAP_CYC - 1);

  logic [DATA_W-1:0] lane_mask;
  logic              hit;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{lane_en[l]}};
  end

  assign hit = in_read && (cnt_q == CAP_AT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= hit || zero_read;
      if (hit)            rsp_rdata <= dq_in & lane_mask;
      else if (zero_read) rsp_rdata <= '0;
    end
  end

  // R4: a result appears only after a read bus cycle or a zero-mask read
  assert_result_source_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(in_read) || $past(zero_read)));

endmodule

// File: rtl/sram_timed_ctrl.sv
`timescale 1ns/1ps
module sram_timed_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int SLOW_GRADE    = 0,
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int T_RC_NS       = (SLOW_GRADE != 0) ? 70 : 55,
  parameter int T_AA_NS       = (SLOW_GRADE != 0) ? 70 : 55,
  parameter int T_DOE_NS      = (SLOW_GRADE != 0) ? 35 : 25,
  parameter int T_WC_NS       = (SLOW_GRADE != 0) ? 70 : 55,
  parameter int T_PWE_NS      = (SLOW_GRADE != 0) ? 45 : 40,
  parameter int T_SD_NS       = (SLOW_GRADE != 0) ? 30 : 25,
  parameter int T_SA_NS       = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_mask,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     sram_addr,
  output logic                  sram_ce_n,
  output logic                  sram_oe_n,
  output logic                  sram_we_n,
  output logic [DATA_W/8-1:0]   sram_be_n,
  output logic [DATA_W-1:0]     sram_dq_out,
  output logic                  sram_dq_oe,
  input  logic [DATA_W-1:0]     sram_dq_in
);

  localparam int LANES   = DATA_W / 8;
  localparam int N_RC    = ns_to_cycles(T_RC_NS, CLK_PERIOD_NS);
  localparam int N_CAP   = max_of(ns_to_cycles(T_AA_NS, CLK_PERIOD_NS),
                                  ns_to_cycles(T_DOE_NS, CLK_PERIOD_NS));
  localparam int N_RDLEN = max_of(N_RC, N_CAP);
  localparam int N_SA    = ns_to_cycles(T_SA_NS, CLK_PERIOD_NS);
  localparam int N_PWE   = max_of(ns_to_cycles(T_PWE_NS, CLK_PERIOD_NS),
                                  ns_to_cycles(T_SD_NS, CLK_PERIOD_NS) + 1);
  localparam int N_WCLEN = max_of(ns_to_cycles(T_WC_NS, CLK_PERIOD_NS),
                                  N_SA + N_PWE + 1);
  localparam int CNT_W   = $clog2(max_of(N_RDLEN, N_WCLEN) + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(N_RDLEN - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(N_WCLEN - 1);

  ctl_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept, bus_req, zero_read, busy, last;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign bus_req   = accept && (req_mask != '0);
  assign zero_read = accept && !req_write && (req_mask == '0);
  assign busy      = (state_q != ST_IDLE);

  always_comb begin
    last = 1'b0;
    if (state_q == ST_READ  && cnt_q == RD_LAST) last = 1'b1;
    if (state_q == ST_WRITE && cnt_q == WR_LAST) last = 1'b1;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (bus_req) state_d = req_write ? ST_WRITE : ST_READ;
      default:  if (last)    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  sram_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .start (bus_req),
    .run   (busy),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d)
  );

  // Address, selects and write data: set on acceptance, held to the end.
  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr   <= '0;
      sram_ce_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_be_n   <= '1;
      sram_dq_out <= '0;
    end else if (bus_req) begin
      sram_addr   <= req_addr;
      sram_ce_n   <= 1'b0;
      sram_oe_n   <= req_write;
      sram_be_n   <= ~req_mask;
      sram_dq_out <= req_wdata;
    end else if (last) begin
      sram_ce_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_be_n   <= '1;
    end
  end

  sram_write_shaper #(
    .CNT_W     (CNT_W),
    .SETUP_CYC (N_SA),
    .PULSE_CYC (N_PWE)
  ) u_wr (
    .clk      (clk),
    .rst      (rst),
    .wr_next  (state_d == ST_WRITE),
    .cnt_next (cnt_d),
    .we_n     (sram_we_n),
    .dq_oe    (sram_dq_oe)
  );

  sram_read_capture #(
    .DATA_W  (DATA_W),
    .LANES   (LANES),
    .CNT_W   (CNT_W),
    .CAP_CYC (N_CAP)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .in_read   (state_q == ST_READ),
    .cnt_q     (cnt_q),
    .lane_en   (~sram_be_n),
    .dq_in     (sram_dq_in),
    .zero_read (zero_read),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // R10: address frozen while the chip is selected
  assert_addr_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

  // R7: a bus request blocks further acceptance
  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_mask != '0) |=> !req_ready);

  // R8: zero-mask request leaves the bus untouched
  assert_zero_mask_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_mask == '0) |=> (sram_ce_n && req_ready));

  // R9: idle means standby
  assert_idle_standby_R9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (sram_ce_n && sram_be_n == '1));

  // R5: strobe low never overlaps output enable low
  assert_strobe_oe_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (sram_oe_n && !sram_ce_n));

  // R6: driving the pins only with memory outputs disabled
  assert_no_contention_R6: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (sram_oe_n && !sram_ce_n));

endmodule

// File: tb/sram_timed_ctrl_test.sv
`timescale 1ns/1ps
module sram_timed_ctrl_test;

  localparam int PER = 5;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction

  // Expected phase lengths from the fast-grade nanosecond figures
  localparam int CAP   = (cyc(55) > cyc(25)) ? cyc(55) : cyc(25);
  localparam int RDLEN = (cyc(55) > CAP) ? cyc(55) : CAP;
  localparam int SA    = cyc(0);
  localparam int PWE   = (cyc(40) > cyc(25) + 1) ? cyc(40) : cyc(25) + 1;
  localparam int WCLEN = (cyc(55) > SA + PWE + 1) ? cyc(55) : SA + PWE + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [1:0]  sram_be_n;
  logic [15:0] sram_dq_out;
  logic [15:0] sram_dq_in = 16'h0;

  sram_timed_ctrl uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_be_n(sram_be_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  always #2.5 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  bit started = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Two memories: one behind the pins, one updated from requests.
  logic [15:0] pin_mem [int];
  logic [15:0] ref_mem [int];

  function automatic logic [15:0] lanes(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  // ---------------- reference model ----------------
  bit          m_busy = 0;
  int          m_off = 0;
  int          m_len = 0;
  bit          m_wr = 0;
  logic [17:0] m_addr = '0;
  logic [15:0] m_wdata = '0;
  logic [1:0]  m_mask = '0;
  bit          e_rsp = 0;
  logic [15:0] e_rdata = '0;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_busy = 0;
      e_rsp  = 0;
    end else begin
      e_rsp = 0;
      if (m_busy) begin
        m_off++;
        if (!m_wr && m_off == CAP) begin
          e_rsp   = 1;
          e_rdata = (ref_mem.exists(int'(m_addr)) ? ref_mem[int'(m_addr)] : 16'h0) & lanes(m_mask);
        end
        if (m_off == m_len) m_busy = 0;
      end else if (req_valid) begin
        if (req_mask == 2'b00) begin
          if (!req_write) begin
            e_rsp   = 1;
            e_rdata = 16'h0;
          end
        end else begin
          m_busy  = 1;
          m_off   = 0;
          m_wr    = req_write;
          m_addr  = req_addr;
          m_wdata = req_wdata;
          m_mask  = req_mask;
          m_len   = req_write ? WCLEN : RDLEN;
          if (req_write) begin
            logic [15:0] old;
            old = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 16'h0;
            ref_mem[int'(req_addr)] = (old & ~lanes(req_mask)) | (req_wdata & lanes(req_mask));
          end
        end
      end
    end
  end

  // ---------------- pin-level memory model ----------------
  int   age = 0;
  logic prev_we_n = 1'b1;

  always @(negedge clk) begin
    if (!sram_ce_n && prev_we_n == 1'b0 && sram_we_n == 1'b1) begin
      logic [15:0] old;
      old = pin_mem.exists(int'(sram_addr)) ? pin_mem[int'(sram_addr)] : 16'h0;
      pin_mem[int'(sram_addr)] = (old & lanes(~sram_be_n)) == 16'h0 && 1'b0 ? old :
                                 ((old & ~lanes(~sram_be_n)) | (sram_dq_out & lanes(~sram_be_n)));
    end
    prev_we_n = sram_we_n;
    if (!sram_ce_n && !sram_oe_n) age++;
    else age = 0;
    if (age >= CAP) begin
      logic [15:0] w;
      w = pin_mem.exists(int'(sram_addr)) ? pin_mem[int'(sram_addr)] : 16'h0;
      sram_dq_in = (w & lanes(~sram_be_n)) | (16'hA5A5 & ~lanes(~sram_be_n));
    end else begin
      sram_dq_in = 16'hC3C3 ^ 16'(age);
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (started && !done) begin
      logic e_ce, e_oe, e_we, e_oen;
      logic [1:0] e_be;
      e_ce  = m_busy ? 1'b0 : 1'b1;
      e_oe  = (m_busy && !m_wr) ? 1'b0 : 1'b1;
      e_be  = m_busy ? ~m_mask : 2'b11;
      e_we  = !(m_busy && m_wr && m_off >= SA && m_off < SA + PWE);
      e_oen = m_busy && m_wr && m_off >= SA + 1 && m_off <= SA + PWE;
      if (rst) begin
        chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
        chk({sram_ce_n, sram_oe_n, sram_we_n, sram_be_n} == 5'h1F, "R1 strobes high in reset",
            32'({sram_ce_n, sram_oe_n, sram_we_n, sram_be_n}), 32'h1F);
        chk(sram_dq_oe == 1'b0 && rsp_valid == 1'b0, "R1 driver and strobe off in reset",
            32'({sram_dq_oe, rsp_valid}), 32'd0);
      end else begin
        chk(req_ready == !m_busy, "R7 R8 ready", 32'(req_ready), 32'(!m_busy));
        chk(sram_ce_n == e_ce, "R3 R9 chip select", 32'(sram_ce_n), 32'(e_ce));
        chk(sram_oe_n == e_oe, "R3 R5 output enable", 32'(sram_oe_n), 32'(e_oe));
        chk(sram_be_n == e_be, "R3 R9 byte enables", 32'(sram_be_n), 32'(e_be));
        chk(sram_we_n == e_we, "R2 R5 write strobe", 32'(sram_we_n), 32'(e_we));
        chk(sram_dq_oe == e_oen, "R6 driver enable", 32'(sram_dq_oe), 32'(e_oen));
        if (m_busy)
          chk(sram_addr == m_addr, "R3 R10 address", 32'(sram_addr), 32'(m_addr));
        if (e_oen)
          chk(sram_dq_out == m_wdata, "R6 write data", 32'(sram_dq_out), 32'(m_wdata));
        chk(rsp_valid == e_rsp, "R2 R4 R8 result strobe", 32'(rsp_valid), 32'(e_rsp));
        if (e_rsp)
          chk(rsp_rdata == e_rdata, "R4 R8 result data", 32'(rsp_rdata), 32'(e_rdata));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_mask  = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic pause(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    pause(2);
    // R3 R4 R5 R6: full-word write and readback
    issue(1, 18'h00010, 16'h1234, 2'b11);
    pause(3);
    issue(0, 18'h00010, 16'h0000, 2'b11);
    pause(3);
    // R10: top address
    issue(1, 18'h3FFFF, 16'hBEEF, 2'b11);
    pause(1);
    issue(0, 18'h3FFFF, 16'h0000, 2'b11);
    pause(2);
    // R3: high-lane-only write, then full read
    issue(1, 18'h00010, 16'hAB99, 2'b10);
    pause(2);
    issue(0, 18'h00010, 16'h0000, 2'b11);
    pause(2);
    // R4: single-lane reads force the other lane to zero
    issue(1, 18'h00020, 16'h5566, 2'b01);
    pause(1);
    issue(0, 18'h00020, 16'h0000, 2'b10);
    pause(1);
    issue(0, 18'h00010, 16'h0000, 2'b01);
    pause(2);
    // R8: zero-mask write and read
    issue(1, 18'h00010, 16'hFFFF, 2'b00);
    issue(0, 18'h00010, 16'h0000, 2'b00);
    pause(2);
    issue(0, 18'h00010, 16'h0000, 2'b11);
    // R7: requests held valid back to back while busy
    issue(1, 18'h00000, 16'h0F0F, 2'b11);
    issue(0, 18'h00000, 16'h0000, 2'b11);
    issue(1, 18'h00001, 16'h7777, 2'b11);
    issue(0, 18'h00001, 16'h0000, 2'b11);
    issue(0, 18'h00123, 16'h0000, 2'b11);
    pause(30);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired, run hung");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule